// File: doc/BRIEF.md
# LIN Transceiver Mode Controller

This block is the clocked control core of a single-wire LIN transceiver. It takes the enable and transmit-data pins from the local controller, the bus level seen by the receive comparator, and two fault flags (supply undervoltage and overtemperature). From these it decides whether the external regulator is kept on, whether the bus driver may pull the line dominant, what level the receive-data pin shows, and whether the slave pull-up termination is connected. Every asynchronous input is resynchronised first. Each decision is then made on filtered levels: a debounced enable, a spike-filtered receive path, and a wakeup filter that is only active while the device sleeps.

After power-on the block waits in a battery-standby mode with the regulator on and the driver off. A debounced high on enable takes it to normal mode. A debounced low on enable while in normal mode puts it to sleep, which releases the regulator and removes the termination. A long enough dominant level on the bus during sleep is a remote wakeup. It returns the block to standby and holds receive-data low as an interrupt until enable is raised again. Overtemperature only blocks the driver and leaves the mode unchanged, so normal traffic resumes as soon as the flag clears.

The block has no data stream. All its pins are plain levels, and it has no valid/ready handshake or back-pressure.

Top module: `lin_phy_ctrl`

## Requirements
- R1: While reset is held and directly after it, the mode is standby, encoded 0. The regulator control is high, the driver is disabled with its data recessive (1), the receive pin is high and the termination is on.
- R2: In standby, enable must be seen high for EN_DEB_CYC consecutive synchronised samples before the block moves to normal mode, encoded 1. A shorter high pulse leaves the mode unchanged.
- R3: Sleep (encoded 2) is entered only from normal mode, after enable has been low for EN_DEB_CYC consecutive samples. A shorter low glitch in normal mode is ignored, and enable low in standby keeps the block in standby.
- R4: In sleep the regulator control is low (output floated), the termination is off, the driver is disabled and the receive pin is high.
- R5: In sleep, a dominant bus level (bus input 0) held for at least WAKE_CYC consecutive samples moves the block to standby with the regulator control high. The receive pin is then held low until the block enters normal mode. Shorter dominant pulses leave the block asleep.
- R6: In sleep, a debounced high on enable moves the block straight to normal mode with no wakeup interrupt, so the receive pin follows the bus.
- R7: In normal mode with no fault, the driver is enabled and its data equals the synchronised transmit pin: 0 drives dominant, 1 releases the bus.
- R8: In normal mode the receive pin shows the bus level, low when dominant. It changes only after the bus has held the new level for RX_DEB_CYC consecutive samples, so shorter pulses never reach the pin.
- R9: Undervoltage in normal mode drops the block to standby and disables the driver. While undervoltage persists, enable high does not enter normal mode. Once it clears, a held enable returns the block to normal mode.
- R10: While the overtemperature flag is set, the driver is disabled and its data is recessive, the mode is kept, and the receive pin still follows the bus. When the flag clears, the driver follows the transmit pin again.
- R11: The mode output only takes the values 0 (standby), 1 (normal) and 2 (sleep). The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all filters and state |
| rst_n | input | 1 | Active-low power-on reset, asynchronous assert |
| en_i | input | 1 | Enable pin from the controller (asynchronous) |
| txd_i | input | 1 | Transmit data pin, 0 = dominant (asynchronous) |
| bus_i | input | 1 | Sampled bus level, 0 = dominant, 1 = recessive (asynchronous) |
| vcc_low_i | input | 1 | Logic-supply undervoltage flag (asynchronous) |
| hot_i | input | 1 | Overtemperature flag (asynchronous) |
| inh_on_o | output | 1 | Regulator control: 1 = drive high, 0 = float |
| drv_en_o | output | 1 | Bus driver enable |
| drv_data_o | output | 1 | Bus driver data, 0 = dominant |
| rxd_o | output | 1 | Receive-data pin level, 0 = dominant or wakeup interrupt |
| term_on_o | output | 1 | Slave termination switch, 1 = connected |
| mode_o | output | 2 | Current mode: 0 standby, 1 normal, 2 sleep |

## Verification
The bench builds the block with EN_DEB_CYC = 8, RX_DEB_CYC = 4 and WAKE_CYC = 20. The default microsecond-scale windows run to thousands of cycles, and these short ones put every filter boundary within a few dozen cycles. This lets random pulse lengths fall on both sides of each threshold, including pulses exactly one sample short of the receive and wakeup windows and a wakeup pulse of exactly WAKE_CYC. With the short windows the bench can also run a full sleep, remote-wakeup, interrupt and re-enable cycle several times, interleaved with undervoltage and overtemperature episodes.

// File: rtl/lin_phy_pkg.sv
package lin_phy_pkg;
  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_NORM  = 2'd1,
    MODE_SLEEP = 2'd2
  } lin_mode_e;

  // bit positions inside the synchroniser bank
  localparam int SIG_EN   = 0;
  localparam int SIG_TXD  = 1;
  localparam int SIG_BUS  = 2;
  localparam int SIG_UV   = 3;
  localparam int SIG_HOT  = 4;
  localparam int SIG_NUM  = 5;
endpackage

// File: rtl/lin_sync_bank.sv
module lin_sync_bank #(
  parameter int W      = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], d[i]};
    end
    assign q[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/lin_level_filter.sv
// Restartable level filter: the output takes a new level only after the
// input has differed from it on LEN consecutive clock edges.
module lin_level_filter #(
  parameter int LEN  = 4,
  parameter bit INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  localparam int CW = $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= INIT;
      cnt <= '0;
    end else if (clr) begin
      q   <= INIT;
      cnt <= '0;
    end else if (d == q) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      q   <= d;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_phy_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en_f,
  input  logic      vcc_low,
  input  logic      wake,
  output lin_mode_e mode,
  output logic      wake_irq
);
  lin_mode_e nxt;
  logic      irq_nxt;

  always_comb begin
    nxt     = mode;
    irq_nxt = wake_irq;
    case (mode)
      MODE_STBY: begin
        if (en_f && !vcc_low) begin
          nxt     = MODE_NORM;
          irq_nxt = 1'b0;
        end
      end
      MODE_NORM: begin
        if (vcc_low)    nxt = MODE_STBY;
        else if (!en_f) nxt = MODE_SLEEP;
      end
      MODE_SLEEP: begin
        if (en_f && !vcc_low) begin
          nxt     = MODE_NORM;
          irq_nxt = 1'b0;
        end else if (wake) begin
          nxt     = MODE_STBY;
          irq_nxt = 1'b1;
        end
      end
      default: begin
        nxt     = MODE_STBY;
        irq_nxt = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= MODE_STBY;
      wake_irq <= 1'b0;
    end else begin
      mode     <= nxt;
      wake_irq <= irq_nxt;
    end
  end
endmodule

// File: rtl/lin_phy_ctrl.sv
module lin_phy_ctrl
  import lin_phy_pkg::*;
#(
  parameter int EN_DEB_CYC  = 4000,
  parameter int RX_DEB_CYC  = 400,
  parameter int WAKE_CYC    = 16000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       txd_i,
  input  logic       bus_i,
  input  logic       vcc_low_i,
  input  logic       hot_i,
  output logic       inh_on_o,
  output logic       drv_en_o,
  output logic       drv_data_o,
  output logic       rxd_o,
  output logic       term_on_o,
  output logic [1:0] mode_o
);
  localparam logic [SIG_NUM-1:0] SYNC_RST =
    SIG_NUM'((1 << SIG_TXD) | (1 << SIG_BUS));

  logic [SIG_NUM-1:0] raw, synced;
  logic en_s, txd_s, bus_s, uv_s, hot_s;
  logic en_f, rx_f, wake;
  lin_mode_e mode;
  logic wake_irq;

  always_comb begin
    raw          = '0;
    raw[SIG_EN]  = en_i;
    raw[SIG_TXD] = txd_i;
    raw[SIG_BUS] = bus_i;
    raw[SIG_UV]  = vcc_low_i;
    raw[SIG_HOT] = hot_i;
  end

  lin_sync_bank #(.W(SIG_NUM), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign en_s  = synced[SIG_EN];
  assign txd_s = synced[SIG_TXD];
  assign bus_s = synced[SIG_BUS];
  assign uv_s  = synced[SIG_UV];
  assign hot_s = synced[SIG_HOT];

  lin_level_filter #(.LEN(EN_DEB_CYC), .INIT(1'b0)) u_en_flt (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .d(en_s), .q(en_f)
  );

  lin_level_filter #(.LEN(RX_DEB_CYC), .INIT(1'b1)) u_rx_flt (
    .clk(clk), .rst_n(rst_n), .clr(1'b0), .d(bus_s), .q(rx_f)
  );

  // wakeup filter only runs while asleep; it counts dominant samples
  lin_level_filter #(.LEN(WAKE_CYC), .INIT(1'b0)) u_wake_flt (
    .clk(clk), .rst_n(rst_n), .clr(mode != MODE_SLEEP), .d(!bus_s), .q(wake)
  );

  lin_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en_f(en_f), .vcc_low(uv_s), .wake(wake),
    .mode(mode), .wake_irq(wake_irq)
  );

  assign inh_on_o   = (mode != MODE_SLEEP);
  assign term_on_o  = (mode != MODE_SLEEP);
  assign drv_en_o   = (mode == MODE_NORM) && !hot_s && !uv_s;
  assign drv_data_o = drv_en_o ? txd_s : 1'b1;
  assign rxd_o      = wake_irq ? 1'b0 : ((mode == MODE_SLEEP) ? 1'b1 : rx_f);
  assign mode_o     = mode;
endmodule

// File: rtl/lin_phy_ctrl_chk.sv
module lin_phy_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       inh_on_o,
  input logic       term_on_o,
  input logic       drv_en_o,
  input logic       rxd_o,
  input logic       hot_q
);
  assert_sleep_from_normal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> $past(mode_o) == 2'd1);

  assert_sleep_outputs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |-> (!inh_on_o && !term_on_o && !drv_en_o));

  assert_wake_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && $past(mode_o) == 2'd2) |-> (!rxd_o && inh_on_o));

  assert_hot_blocks_driver_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hot_q |-> !drv_en_o);

  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 2'd3);
endmodule

bind lin_phy_ctrl lin_phy_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o), .inh_on_o(inh_on_o),
  .term_on_o(term_on_o), .drv_en_o(drv_en_o), .rxd_o(rxd_o), .hot_q(hot_s)
);

// File: tb/lin_phy_ctrl_bench.sv
`timescale 1ns/1ps
module lin_phy_ctrl_bench;
  localparam int EN_DEB = 8;
  localparam int RX_DEB = 4;
  localparam int WAKE   = 20;

  logic clk = 1'b0;
  logic rst_n, en, txd, bus, uv, hot;
  logic inh, drv_en, drv_data, rxd, term;
  logic [1:0] mode;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lin_phy_ctrl #(.EN_DEB_CYC(EN_DEB), .RX_DEB_CYC(RX_DEB), .WAKE_CYC(WAKE)) u_lin_phy_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .txd_i(txd), .bus_i(bus),
    .vcc_low_i(uv), .hot_i(hot), .inh_on_o(inh), .drv_en_o(drv_en),
    .drv_data_o(drv_data), .rxd_o(rxd), .term_on_o(term), .mode_o(mode)
  );

  function automatic bit exp_drv_data(bit t, bit h);
    return h ? 1'b1 : t;
  endfunction
  function automatic bit exp_rx_low(int p);
    return p >= RX_DEB;
  endfunction
  function automatic bit exp_wake(int p);
    return p >= WAKE;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // drive a dominant pulse of p samples and report whether rxd ever fell
  task automatic rx_pulse(int p, output bit low_seen);
    low_seen = 0;
    bus = 1'b0;
    repeat (p) begin
      @(negedge clk);
      if (!rxd) low_seen = 1;
    end
    bus = 1'b1;
    repeat (RX_DEB + 6) begin
      @(negedge clk);
      if (!rxd) low_seen = 1;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    bit low;
    bit t;
    bit h;
    int p;
    void'($urandom(32'd1234));
    rst_n = 0; en = 0; txd = 1; bus = 1; uv = 0; hot = 0;
    step(3);
    chk("R1 mode", mode, 0);
    chk("R1 inh", inh, 1);
    chk("R1 drv_en", drv_en, 0);
    chk("R1 drv_data", drv_data, 1);
    chk("R1 rxd", rxd, 1);
    chk("R1 term", term, 1);
    rst_n = 1;
    step(EN_DEB * 3);
    chk("R3 standby holds with EN low", mode, 0);

    // R2: short enable pulse ignored, then held enable
    en = 1; step(EN_DEB - 1); en = 0; step(EN_DEB + 4);
    chk("R2 short EN pulse", mode, 0);
    en = 1; step(EN_DEB + 4);
    chk("R2 enter normal", mode, 1);

    // R7 / R10: random transmit data with random overtemperature
    for (int i = 0; i < 60; i++) begin
      t = 1'($urandom);
      h = ($urandom_range(0, 3) == 0);
      txd = t; hot = h;
      step(3);
      chk("R7/R10 drv_en", drv_en, !h);
      chk("R7/R10 drv_data", drv_data, exp_drv_data(t, h));
      chk("R10 R11 mode kept normal", mode, 1);
    end
    hot = 0; txd = 0; step(3);
    chk("R10 driver resumes after recovery", drv_data, 0);
    txd = 1; step(3);

    // R8 / R10: receive spike filter, sometimes with overtemperature
    for (int i = 0; i < 24; i++) begin
      p = $urandom_range(1, 2 * RX_DEB);
      if (i == 0) p = RX_DEB - 1;
      if (i == 1) p = RX_DEB;
      hot = ($urandom_range(0, 2) == 0);
      rx_pulse(p, low);
      chk("R8 rx filter", low, exp_rx_low(p));
      chk("R8 rxd idle high", rxd, 1);
    end
    hot = 0; step(3);

    // R9: undervoltage
    uv = 1; step(4);
    chk("R9 uv drops to standby", mode, 0);
    chk("R9 uv driver off", drv_en, 0);
    step(12);
    chk("R9 no normal under uv", mode, 0);
    uv = 0; step(4);
    chk("R9 back to normal", mode, 1);

    // R3: short EN low glitch ignored, then sleep
    en = 0; step(EN_DEB - 1); en = 1; step(EN_DEB + 4);
    chk("R3 short EN low", mode, 1);
    txd = 0;
    en = 0; step(EN_DEB + 4);
    chk("R3 enter sleep", mode, 2);
    chk("R4 inh floated", inh, 0);
    chk("R4 term off", term, 0);
    chk("R4 driver off", drv_en, 0);
    chk("R4 driver recessive", drv_data, 1);
    chk("R4 rxd high", rxd, 1);
    txd = 1;

    // R5: short dominant pulses do not wake
    for (int i = 0; i < 10; i++) begin
      p = (i == 0) ? WAKE - 1 : $urandom_range(1, WAKE - 1);
      bus = 0; step(p); bus = 1; step(4);
      chk("R5 short pulse ignored", mode, exp_wake(p) ? 0 : 2);
    end
    bus = 0; step(WAKE); bus = 1; step(4);
    chk("R5 remote wake mode", mode, 0);
    chk("R5 remote wake inh", inh, 1);
    chk("R5 wake interrupt", rxd, 0);
    step(30);
    chk("R5 interrupt held", rxd, 0);
    en = 1; step(EN_DEB + 4);
    chk("R5 normal after wake", mode, 1);
    chk("R5 interrupt released", rxd, 1);

    // R6: local wakeup from sleep
    en = 0; step(EN_DEB + 4);
    chk("R6 asleep again", mode, 2);
    en = 1; step(EN_DEB + 4);
    chk("R6 local wake to normal", mode, 1);
    chk("R6 no interrupt", rxd, 1);
    chk("R6 inh on", inh, 1);

    finish_run();
  end
endmodule